// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns one burst request into the series of column addresses that a synchronous DRAM burst visits. A one-cycle start pulse captures a start column, a burst-length code (1, 2, 4 or 8 beats) and an ordering mode, which is either sequential wrap or XOR interleave. The generator then presents one address per beat on a valid/ready output stream and marks the final beat. Every address stays inside the aligned block of columns that contains the start column, and that block is as large as the burst.

The output follows valid/ready rules. A beat is consumed on a clock edge where `col_valid` and `col_ready` are both high. While `col_valid` is high and `col_ready` is low, the address and the last flag stay frozen. The stream drops `col_valid` after the last beat is consumed. Control inputs are plain: the burst parameters are sampled only on the edge where `start` is high. A start pulse aborts any burst in progress, and a start on the same edge as a handshake takes priority.

Top module: `burst_col_gen`

## Requirements
- R1: After reset `col_valid` is low and stays low until a start pulse.
- R2: On the cycle after a start pulse, `col_valid` is high and `col_addr` equals the captured start column (beat 0).
- R3: Sequential mode (`wrap_sel`=0): on beat i, the low log2(BL) bits equal (start low bits + i) mod BL, and the upper bits are those of the start column.
- R4: Interleaved mode (`wrap_sel`=1): on beat i, the low log2(BL) bits equal the start low bits XOR i, and the upper bits are held. With BL 8 and start 2, the order is 2,3,0,1,6,7,4,5.
- R5: `bl_sel` encodes the burst length as 0→1, 1→2, 2→4, 3→8 beats. Exactly that many beats are emitted, and all of them lie in the aligned segment of that size holding the start column.
- R6: `col_last` is high together with beat BL-1 only. After that beat is consumed without a new start, `col_valid` is low on the next cycle.
- R7: With `bl_sel`=0, one beat carrying the start column is emitted, with `col_last` high.
- R8: While `col_valid` is high and `col_ready` low, `col_addr` and `col_last` hold their values and no beat is lost.
- R9: A start pulse during a burst restarts at beat 0 with the new parameters, and takes priority over a handshake on the same edge.
- R10: Changes to `start_col`, `bl_sel` and `wrap_sel` while `start` is low have no effect on the burst in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that captures the burst parameters |
| start_col | input | COL_W | Start column address |
| bl_sel | input | 2 | Burst length code: 0=1, 1=2, 2=4, 3=8 |
| wrap_sel | input | 1 | 0 = sequential wrap, 1 = interleaved |
| col_valid | output | 1 | Output address is valid |
| col_ready | input | 1 | Consumer accepts the current address |
| col_addr | output | COL_W | Current column address |
| col_last | output | 1 | Current beat is the final beat |

## Verification
The bench checks wrap at the segment edge. For example, a sequential BL 4 burst from column 6 must give 6,7,4,5. A generator that carried out of the low bits would step into the next segment. Interleaved ordering is checked against the 2,3,0,1,6,7,4,5 pattern, which a sequential-only design would get wrong from the third beat. Stalls, single-beat bursts and a restart in mid-burst are also covered. Each would show up as a repeated or skipped address, a missing last flag, or leftover beats of the aborted burst. Inputs that change in mid-burst would show up as corrupted addresses if the design did not hold its captured parameters.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  localparam int unsigned BEAT_W = 3;   // enough for the longest burst (8)
  localparam int unsigned BLSEL_W = 2;

  typedef enum logic {
    ORDER_SEQ   = 1'b0,
    ORDER_INTLV = 1'b1
  } order_e;

  typedef struct packed {
    logic [BLSEL_W-1:0] len_code;
    order_e             order;
  } burst_cfg_t;
endpackage

// File: rtl/bcg_beat_ctr.sv
module bcg_beat_ctr
  import bcg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              fire_i,
  input  logic [BLSEL_W-1:0] len_code_i,
  output logic              busy_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic              final_o
);
  logic [BEAT_W-1:0] lim;

  // final beat index = BL-1
  assign lim     = BEAT_W'((1 << len_code_i) - 1);
  assign final_o = (beat_o == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      beat_o <= '0;
    end else if (load_i) begin
      busy_o <= 1'b1;
      beat_o <= '0;
    end else if (fire_i) begin
      if (final_o) begin
        busy_o <= 1'b0;
        beat_o <= '0;
      end else begin
        beat_o <= beat_o + BEAT_W'(1);
      end
    end
  end

  // R6: the beat index never runs past the final beat of the burst
  a_r6_beat_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (beat_o <= lim));
endmodule

// File: rtl/bcg_order.sv
module bcg_order
  import bcg_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic [COL_W-1:0]   base_i,
  input  logic [BEAT_W-1:0]  beat_i,
  input  logic [BLSEL_W-1:0] len_code_i,
  input  order_e             order_i,
  output logic [COL_W-1:0]   addr_o
);
  logic [COL_W-1:0] seg_mask;
  logic [COL_W-1:0] beat_ext;
  logic [COL_W-1:0] low_bits;

  assign seg_mask = (COL_W'(1) << len_code_i) - COL_W'(1);
  assign beat_ext = COL_W'(beat_i);

  always_comb begin
    unique case (order_i)
      ORDER_INTLV: low_bits = (base_i ^ beat_ext) & seg_mask;
      default:     low_bits = (base_i + beat_ext) & seg_mask;
    endcase
  end

  assign addr_o = (base_i & ~seg_mask) | low_bits;
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import bcg_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [1:0]       bl_sel,
  input  logic             wrap_sel,
  output logic             col_valid,
  input  logic             col_ready,
  output logic [COL_W-1:0] col_addr,
  output logic             col_last
);
  burst_cfg_t        cfg_q;
  logic [COL_W-1:0]  base_q;
  logic [BEAT_W-1:0] beat;
  logic              busy;
  logic              is_final;
  logic              fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '{len_code: '0, order: ORDER_SEQ};
      base_q <= '0;
    end else if (start) begin
      cfg_q  <= '{len_code: bl_sel, order: order_e'(wrap_sel)};
      base_q <= start_col;
    end
  end

  assign fire = col_valid && col_ready;

  bcg_beat_ctr u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (start),
    .fire_i    (fire),
    .len_code_i(cfg_q.len_code),
    .busy_o    (busy),
    .beat_o    (beat),
    .final_o   (is_final)
  );

  bcg_order #(.COL_W(COL_W)) u_order (
    .base_i    (base_q),
    .beat_i    (beat),
    .len_code_i(cfg_q.len_code),
    .order_i   (cfg_q.order),
    .addr_o    (col_addr)
  );

  assign col_valid = busy;
  assign col_last  = busy && is_final;

  // R2: first beat is the captured start column
  a_r2_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (col_valid && col_addr == $past(start_col)));

  // R7: single-beat burst is flagged last at once
  a_r7_single_last: assert property (@(posedge clk) disable iff (!rst_n)
    (start && bl_sel == 2'd0) |=> col_last);

  // R6: consuming the last beat ends the stream
  a_r6_drop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && col_last && !start) |=> !col_valid);

  // R8: back-pressure freezes the beat
  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !col_ready && !start) |=>
      (col_valid && $stable(col_addr) && $stable(col_last)));

  // R5: upper address bits stay in the start segment while busy
  a_r5_same_segment: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !start && !$past(start)) |=>
      (!col_valid || (col_addr >> 3) == ($past(col_addr) >> 3)));
endmodule

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb;
  localparam int COL_W = 9;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic [1:0]       bl_sel = '0;
  logic             wrap_sel = 1'b0;
  logic             col_valid;
  logic             col_ready = 1'b0;
  logic [COL_W-1:0] col_addr;
  logic             col_last;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  burst_col_gen #(.COL_W(COL_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .bl_sel(bl_sel), .wrap_sel(wrap_sel), .col_valid(col_valid),
    .col_ready(col_ready), .col_addr(col_addr), .col_last(col_last)
  );

  function automatic logic [COL_W-1:0] exp_addr(input logic [COL_W-1:0] c,
      input int blsel, input bit intl, input int i);
    int n = 1 << blsel;
    int lo;
    int base = int'(c) - (int'(c) % n);
    if (intl) lo = (int'(c) ^ i) % n;
    else      lo = (int'(c) + i) % n;
    return COL_W'(base + lo);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [COL_W-1:0] c, input int bs, input bit w);
    @(negedge clk);
    start = 1'b1; start_col = c; bl_sel = 2'(bs); wrap_sel = w;
    @(negedge clk);
    start = 1'b0;
  endtask

  // full burst; stall_mask bit i holds ready low for one cycle on beat i
  task automatic run_burst(input string req, input logic [COL_W-1:0] c,
      input int bs, input bit w, input int stall_mask);
    int n = 1 << bs;
    pulse(c, bs, w);
    for (int i = 0; i < n; i++) begin
      if (stall_mask[i]) begin
        col_ready = 1'b0;
        @(negedge clk);
        chk({req, " R8 stall valid"}, int'(col_valid), 1);
        chk({req, " R8 stall addr"}, int'(col_addr), int'(exp_addr(c, bs, w, i)));
      end
      chk({req, " valid"}, int'(col_valid), 1);
      chk({req, " addr"}, int'(col_addr), int'(exp_addr(c, bs, w, i)));
      chk({req, " R6 last"}, int'(col_last), int'(i == n - 1));
      col_ready = 1'b1;
      @(negedge clk);
    end
    chk({req, " R6 end"}, int'(col_valid), 0);
    col_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset valid", int'(col_valid), 0);
    @(negedge clk);
    chk("R1 idle valid", int'(col_valid), 0);
  endtask

  task automatic t_seq_wrap();
    logic [COL_W-1:0] want [4] = '{9'd6, 9'd7, 9'd4, 9'd5};
    pulse(9'd6, 2, 1'b0);
    col_ready = 1'b1;
    for (int i = 0; i < 4; i++) begin
      chk("R3 seq bl4 from 6", int'(col_addr), int'(want[i]));
      @(negedge clk);
    end
    col_ready = 1'b0;
  endtask

  task automatic t_intlv8();
    logic [COL_W-1:0] want [8] = '{9'd2, 9'd3, 9'd0, 9'd1, 9'd6, 9'd7, 9'd4, 9'd5};
    pulse(9'd2, 3, 1'b1);
    chk("R2 first beat", int'(col_addr), 2);
    col_ready = 1'b1;
    for (int i = 0; i < 8; i++) begin
      chk("R4 intlv bl8 from 2", int'(col_addr), int'(want[i]));
      @(negedge clk);
    end
    chk("R6 end intlv", int'(col_valid), 0);
    col_ready = 1'b0;
  endtask

  task automatic t_sweep();
    for (int b = 0; b < 4; b++) begin
      run_burst("R5 R3 sweep seq", 9'h1F5, b, 1'b0, 0);
      run_burst("R5 R4 sweep intlv", 9'h0AB, b, 1'b1, 0);
    end
  endtask

  task automatic t_single();
    pulse(9'h133, 0, 1'b1);
    chk("R7 single addr", int'(col_addr), 'h133);
    chk("R7 single last", int'(col_last), 1);
    col_ready = 1'b1;
    @(negedge clk);
    chk("R7 single done", int'(col_valid), 0);
    col_ready = 1'b0;
  endtask

  task automatic t_stall();
    run_burst("R8 stall seq", 9'h07E, 3, 1'b0, 'b1010_0101);
    run_burst("R8 stall intlv", 9'h0C5, 2, 1'b1, 'b0110);
  endtask

  task automatic t_restart();
    pulse(9'h010, 3, 1'b1);
    col_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    start = 1'b1; start_col = 9'h023; bl_sel = 2'd1; wrap_sel = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk("R9 restart addr0", int'(col_addr), 'h023);
    chk("R9 restart last0", int'(col_last), 0);
    @(negedge clk);
    chk("R9 restart addr1", int'(col_addr), 'h022);
    chk("R9 restart last1", int'(col_last), 1);
    @(negedge clk);
    chk("R9 restart end", int'(col_valid), 0);
    col_ready = 1'b0;
  endtask

  task automatic t_ignore();
    pulse(9'h041, 2, 1'b1);
    start_col = 9'h1FF; bl_sel = 2'd0; wrap_sel = 1'b0;
    col_ready = 1'b1;
    for (int i = 0; i < 4; i++) begin
      chk("R10 ignored inputs addr", int'(col_addr), int'(exp_addr(9'h041, 2, 1'b1, i)));
      chk("R10 ignored inputs last", int'(col_last), int'(i == 3));
      @(negedge clk);
    end
    chk("R10 ignored end", int'(col_valid), 0);
    col_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_seq_wrap();
    t_intlv8();
    t_sweep();
    t_single();
    t_stall();
    t_restart();
    t_ignore();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule